// File: doc/BRIEF.md
# Cluster Allocator With Wide Chains

This block is the routing fabric between sixteen product-term cluster sums and sixteen macrocell logic inputs. Each cluster sum is sent to exactly one macrocell in a small neighbourhood around its own slice. Each macrocell ORs together every cluster sum that arrives at it. Neighbour steering alone lets one macrocell collect up to four clusters, which is about twenty product terms.

For wider functions, a slice can forward its whole allocator sum four slices ahead. The slices form four chains (slices 0/4/8/12, 1/5/9/13, 2/6/10/14 and 3/7/11/15), and each chain wraps from the top of the array back to the bottom. A chain of four slices gathers about eighty product terms at its last slice. A forwarding slice drives a logic-0 macrocell output.

The steering configuration is static input data. The block does not try to repair a configuration that cannot be realised. Instead it raises a configuration-error flag and grounds what that configuration would have fed. The outputs are registered, so results appear one clock after the inputs.

Top module: `cluster_alloc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `mc_sum` becomes all zero and `cfg_err` becomes 0 after that edge.
- R2: Cluster c's destination code sits in `dst_code[2c+1:2c]`. Code 00 sends it to macrocell c, 01 to macrocell c-1, 10 to macrocell c-2 and 11 to macrocell c+1. Each cluster reaches exactly one macrocell.
- R3: A macrocell's local sum is the OR of all cluster sums steered to it. A macrocell that receives no set cluster sum and no forwarded sum outputs 0.
- R4: A code that points outside slices 0..15 sets `cfg_err`, and that cluster contributes to no output. The illegal cases are: 01 or 10 at cluster 0, 10 at cluster 1, and 11 at cluster 15.
- R5: When `wide_fwd[n]` is 1, the allocator sum of slice n is ORed into the allocator sum of slice n+4.
- R6: When `wide_fwd[n]` is 1, `mc_sum[n]` is 0 whatever its clusters carry.
- R7: Forwarding wraps around, so slice 12 feeds slice 0, 13 feeds 1, 14 feeds 2 and 15 feeds 3.
- R8: Forwarding chains over several hops: a cluster sum at slice n with `wide_fwd` set at n and n+4 (and n+8) appears at n+8 (or n+12).
- R9: When all four slices of one chain group have `wide_fwd` set, `cfg_err` is 1 and every output of that group is 0.
- R10: Outputs are registered. A change on any input shows at `mc_sum`/`cfg_err` only after the next rising clock edge.
- R11: When no destination code is out of range and no chain group is a full loop, `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clus_sum | input | 16 | One OR-of-product-terms sum per cluster |
| dst_code | input | 32 | Two-bit destination code per cluster, cluster c at bits [2c+1:2c] |
| wide_fwd | input | 16 | Per-slice enable that forwards the allocator sum four slices ahead |
| mc_sum | output | 16 | Registered logic sum per macrocell |
| cfg_err | output | 1 | Registered flag for an unrealisable configuration |

## Verification
The bench sweeps every destination code on every cluster, including the four edge cases that fall off the array. A design that clipped or wrapped those cases, instead of dropping them and flagging the error, would light a wrong macrocell and keep `cfg_err` low. It drives every single-slice forward, every two-hop and three-hop chain, and every full loop. A design that forwarded without wrapping, or that left the forwarding slice's output live, would show a 1 on the wrong slice. Thousands of random configurations are compared against a forward-tracing model in the bench. This catches a dropped OR term or a chain that ignores a break in the middle.

// File: rtl/ca_pkg.sv
// Shared definitions for the cluster allocator.
// Assumes destination codes are two bits wide; the offsets are fixed by the code table.
package ca_pkg;

    typedef enum logic [1:0] {
        DST_SAME = 2'b00,
        DST_DN1  = 2'b01,
        DST_DN2  = 2'b10,
        DST_UP1  = 2'b11
    } dst_code_e;

    // Signed slice offset selected by a destination code.
    function automatic int dst_delta(input dst_code_e code);
        case (code)
            DST_SAME: return 0;
            DST_DN1:  return -1;
            DST_DN2:  return -2;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/ca_cluster_router.sv
// Neighbour steering: each cluster sum goes to one macrocell within its window,
// and each macrocell ORs all arrivals. Destinations off the array are dropped
// and reported. Purely combinational; assumes N_SLICE >= 3.
module ca_cluster_router
    import ca_pkg::*;
#(
    parameter int N_SLICE = 16
) (
    input  logic [N_SLICE-1:0]   clus_sum,
    input  logic [2*N_SLICE-1:0] dst_code,
    output logic [N_SLICE-1:0]   local_sum,
    output logic                 range_err
);

    localparam int IW = $clog2(N_SLICE);

    // Scatter every cluster into its destination slice, flagging out-of-range targets.
    always_comb begin
        local_sum = '0;
        range_err = 1'b0;
        for (int c = 0; c < N_SLICE; c++) begin
            int d;
            d = c + dst_delta(dst_code_e'(dst_code[2*c +: 2]));
            if (d < 0 || d >= N_SLICE) begin
                range_err = 1'b1;
            end else begin
                local_sum[IW'(d)] = local_sum[IW'(d)] | clus_sum[c];
            end
        end
    end

endmodule

// File: rtl/ca_wide_chain.sv
// Wide steering: a slice's allocator sum is forwarded CHAIN_STRIDE slices ahead
// (with wrap-around) when its enable is set, and a forwarding slice outputs 0.
// Built as an unrolled gather per slice so no combinational loop exists even
// when a group's enables close into a ring; that ring is reported instead.
// Assumes N_SLICE is a multiple of CHAIN_STRIDE.
module ca_wide_chain #(
    parameter int N_SLICE      = 16,
    parameter int CHAIN_STRIDE = 4
) (
    input  logic [N_SLICE-1:0] local_sum,
    input  logic [N_SLICE-1:0] wide_fwd,
    output logic [N_SLICE-1:0] slice_out,
    output logic               loop_err
);

    localparam int IW    = $clog2(N_SLICE);
    localparam int CHAIN = N_SLICE / CHAIN_STRIDE;

    logic [N_SLICE-1:0]      alloc_sum;
    logic [CHAIN_STRIDE-1:0] grp_ring;

    // Gather for each slice the local sums of an unbroken run of forwarding predecessors.
    always_comb begin
        for (int n = 0; n < N_SLICE; n++) begin
            logic live;
            logic acc;
            live = 1'b1;
            acc  = local_sum[n];
            for (int k = 1; k < CHAIN; k++) begin
                int idx;
                idx  = (n + N_SLICE - ((k * CHAIN_STRIDE) % N_SLICE)) % N_SLICE;
                live = live & wide_fwd[IW'(idx)];
                acc  = acc | (live & local_sum[IW'(idx)]);
            end
            alloc_sum[n] = acc;
        end
    end

    // Ground the macrocell output of every slice that forwards its sum.
    always_comb begin
        slice_out = alloc_sum & ~wide_fwd;
    end

    // Detect chain groups whose enables are all set (a closed ring).
    generate
        for (genvar g = 0; g < CHAIN_STRIDE; g++) begin : g_ring
            always_comb begin
                grp_ring[g] = 1'b1;
                for (int j = 0; j < CHAIN; j++) begin
                    grp_ring[g] = grp_ring[g] & wide_fwd[g + j*CHAIN_STRIDE];
                end
            end
        end
    endgenerate

    // Any closed ring is an unrealisable configuration.
    always_comb begin
        loop_err = |grp_ring;
    end

endmodule

// File: rtl/ca_out_stage.sv
// Output register for the macrocell sums and the error flag.
// Synchronous active-low reset clears both.
module ca_out_stage #(
    parameter int N_SLICE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLICE-1:0] sum_d,
    input  logic               err_d,
    output logic [N_SLICE-1:0] sum_q,
    output logic               err_q
);

    // Capture the routed sums and error flag each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            err_q <= 1'b0;
        end else begin
            sum_q <= sum_d;
            err_q <= err_d;
        end
    end

endmodule

// File: rtl/cluster_alloc_top.sv
// Cluster allocator with wide chains: neighbour steering, four-slice forward
// chains with wrap-around, and a registered output stage. The configuration
// is treated as static data; illegal settings raise cfg_err and are grounded.
module cluster_alloc_top #(
    parameter int N_SLICE      = 16,
    parameter int CHAIN_STRIDE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SLICE-1:0]   clus_sum,
    input  logic [2*N_SLICE-1:0] dst_code,
    input  logic [N_SLICE-1:0]   wide_fwd,
    output logic [N_SLICE-1:0]   mc_sum,
    output logic                 cfg_err
);

    logic [N_SLICE-1:0] local_sum;
    logic [N_SLICE-1:0] slice_out;
    logic               range_err;
    logic               loop_err;
    logic               err_any;

    ca_cluster_router #(.N_SLICE(N_SLICE)) u_router (
        .clus_sum  (clus_sum),
        .dst_code  (dst_code),
        .local_sum (local_sum),
        .range_err (range_err)
    );

    ca_wide_chain #(.N_SLICE(N_SLICE), .CHAIN_STRIDE(CHAIN_STRIDE)) u_chain (
        .local_sum (local_sum),
        .wide_fwd  (wide_fwd),
        .slice_out (slice_out),
        .loop_err  (loop_err)
    );

    // Merge both error sources into one flag.
    always_comb begin
        err_any = range_err | loop_err;
    end

    ca_out_stage #(.N_SLICE(N_SLICE)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .sum_d (slice_out),
        .err_d (err_any),
        .sum_q (mc_sum),
        .err_q (cfg_err)
    );

endmodule

// File: rtl/ca_alloc_chk.sv
// Property checker for cluster_alloc_top, bound to every instance.
// Observes only the top-level ports plus a ring flag it derives itself.
module ca_alloc_chk #(
    parameter int N_SLICE      = 16,
    parameter int CHAIN_STRIDE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SLICE-1:0]   clus_sum,
    input logic [N_SLICE-1:0]   wide_fwd,
    input logic [N_SLICE-1:0]   mc_sum,
    input logic                 cfg_err
);

    localparam int CHAIN = N_SLICE / CHAIN_STRIDE;

    logic ring_seen;

    // Independent view of whether any chain group is a closed ring.
    always_comb begin
        ring_seen = 1'b0;
        for (int g = 0; g < CHAIN_STRIDE; g++) begin
            logic all_on;
            all_on = 1'b1;
            for (int j = 0; j < CHAIN; j++) begin
                all_on = all_on & wide_fwd[g + j*CHAIN_STRIDE];
            end
            ring_seen = ring_seen | all_on;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (mc_sum == '0 && !cfg_err)); // R1

    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(mc_sum) <= $countones($past(clus_sum)))); // R2

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (clus_sum == '0) |=> (mc_sum == '0)); // R3

    AST_FWD_GROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((mc_sum & $past(wide_fwd)) == '0)); // R6

    AST_RING_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ring_seen |=> cfg_err); // R9

endmodule

bind cluster_alloc_top ca_alloc_chk #(
    .N_SLICE      (N_SLICE),
    .CHAIN_STRIDE (CHAIN_STRIDE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clus_sum (clus_sum),
    .wide_fwd (wide_fwd),
    .mc_sum   (mc_sum),
    .cfg_err  (cfg_err)
);

// File: tb/sim_cluster_alloc_top.sv
// Sweep bench for cluster_alloc_top: exhaustive destination codes, all chain
// shapes, and random configurations against a forward-tracing model.
module sim_cluster_alloc_top;

    localparam int N = 16;
    localparam int S = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  clus_sum = '0;
    logic [2*N-1:0] dst_code = '0;
    logic [N-1:0]  wide_fwd = '0;
    logic [N-1:0]  mc_sum;
    logic          cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cluster_alloc_top #(.N_SLICE(N), .CHAIN_STRIDE(S)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clus_sum (clus_sum),
        .dst_code (dst_code),
        .wide_fwd (wide_fwd),
        .mc_sum   (mc_sum),
        .cfg_err  (cfg_err)
    );

    // Model: scatter clusters by code, then trace each slice forward along its chain.
    function automatic void model(input logic [N-1:0] cl, input logic [2*N-1:0] dc,
                                  input logic [N-1:0] we,
                                  output logic [N-1:0] es, output logic ee);
        logic [N-1:0] loc;
        loc = '0; es = '0; ee = 1'b0;
        for (int c = 0; c < N; c++) begin
            int d;
            case (dc[2*c +: 2])
                2'b00: d = c;
                2'b01: d = c - 1;
                2'b10: d = c - 2;
                default: d = c + 1;
            endcase
            if (d < 0 || d > N-1) ee = 1'b1;
            else if (cl[c]) loc[d] = 1'b1;
        end
        for (int g = 0; g < S; g++)
            if (we[g] && we[g+S] && we[g+2*S] && we[g+3*S]) ee = 1'b1;
        for (int n = 0; n < N; n++) begin
            if (loc[n]) begin
                int m;
                int steps;
                m = n; steps = 0;
                while (we[m] && steps < N/S) begin
                    m = (m + S) % N;
                    steps++;
                end
                if (steps < N/S) es[m] = 1'b1;
            end
        end
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s mc_sum actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cfg_err actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one configuration at a falling edge and compare one cycle later.
    task automatic run_vec(input string tag, input logic [N-1:0] cl,
                           input logic [2*N-1:0] dc, input logic [N-1:0] we);
        logic [N-1:0] es;
        logic ee;
        @(negedge clk);
        clus_sum = cl; dst_code = dc; wide_fwd = we;
        model(cl, dc, we, es, ee);
        @(negedge clk);
        check_vec(tag, mc_sum, es);
        check_bit(tag, cfg_err, ee);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] es;
        logic ee;
        // R1: reset state, with live inputs present
        clus_sum = '1; wide_fwd = 16'h0011;
        repeat (3) @(negedge clk);
        check_vec("R1", mc_sum, '0);
        check_bit("R1", cfg_err, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        clus_sum = '0; wide_fwd = '0;

        // R2/R4: every code on every cluster, single active cluster
        for (int c = 0; c < N; c++) begin
            for (int code = 0; code < 4; code++) begin
                logic [2*N-1:0] dc;
                bit bad;
                dc = '0;
                dc[2*c +: 2] = 2'(code);
                bad = (c == 0 && (code == 1 || code == 2)) || (c == 1 && code == 2)
                      || (c == N-1 && code == 3);
                run_vec(bad ? "R4" : "R2", 16'(1) << c, dc, '0);
                if (!bad) run_vec("R11", 16'(1) << c, dc, '0);
            end
        end

        // R3: two neighbours steered together, all input combinations
        for (int c = 0; c < N-1; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [2*N-1:0] dc;
                dc = '0;
                dc[2*(c+1) +: 2] = 2'b01;
                run_vec("R3", 16'(p) << c, dc, '0);
            end
        end

        // R5/R6/R7: single forward from every slice
        for (int n = 0; n < N; n++) begin
            run_vec(n >= N-S ? "R7" : "R5", 16'(1) << n, '0, 16'(1) << n);
            run_vec("R6", (16'(1) << n) | (16'(1) << ((n+S)%N)), '0, 16'(1) << n);
        end

        // R8: two-hop and three-hop chains from every slice
        for (int n = 0; n < N; n++) begin
            logic [N-1:0] we2;
            logic [N-1:0] we3;
            we2 = (16'(1) << n) | (16'(1) << ((n+S)%N));
            we3 = we2 | (16'(1) << ((n+2*S)%N));
            run_vec("R8", 16'(1) << n, '0, we2);
            run_vec("R8", 16'(1) << n, '0, we3);
        end

        // R9: full ring on each group
        for (int g = 0; g < S; g++) begin
            logic [N-1:0] we;
            we = '0;
            for (int j = 0; j < N/S; j++) we[g + j*S] = 1'b1;
            run_vec("R9", '1, '0, we);
        end

        // R10: output holds until the next rising edge
        run_vec("R10", 16'h0001, '0, '0);
        @(negedge clk);
        clus_sum = 16'h0100;
        #1;
        check_vec("R10", mc_sum, 16'h0001);
        @(negedge clk);
        check_vec("R10", mc_sum, 16'h0100);

        // R3/R11: random configurations against the model
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] we;
            we = 16'($urandom);
            if (i % 3 != 0) we = we & 16'($urandom);
            run_vec("R11", 16'($urandom), {$urandom, $urandom}, we);
        end

        // R1: reset in the middle of traffic
        @(negedge clk);
        clus_sum = '1; dst_code = '0; wide_fwd = '0;
        rst_n = 1'b0;
        model('1, '0, '0, es, ee);
        @(negedge clk);
        check_vec("R1", mc_sum, '0);
        check_bit("R1", cfg_err, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule